// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block samples the control pins of a double-data-rate SDRAM on every rising clock edge and turns each legal command into a single-cycle strobe. The strobe carries the command code, the target bank, the row and column, and an auto-precharge flag. The block keeps a table that records, for each bank, whether a row is open and which row it is. It stores the values written to the mode register and to the extended mode register. It also follows the clock-enable pin through four states: active, precharge power-down, active power-down and self refresh.

An illegal sequence raises a one-cycle protocol-error pulse and leaves the tracked state unchanged. Examples are opening a bank that is already open, accessing a closed bank, refreshing with a row open, and dropping clock enable during a burst. The block can sit beside a controller's command path or inside a checker that watches a memory bus.

All outputs are registered. A command sampled at edge k appears on the outputs just after edge k.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset, every bank is closed, both mode registers read zero, `pwr_state_o` is 0 (active), and `cmd_valid_o` and `proto_err_o` are low.
- R2: While the block is active and `cke_i` is high, a command is decoded from `{ras_ni,cas_ni,we_ni}` when `cs_ni` is low. The codes are 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 LOAD MODE, 110 BURST STOP and 111 NOP. An accepted command pulses `cmd_valid_o` with `cmd_o` set to 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF, 6 MRS, 7 BST, or 8 for self-refresh entry. When `cs_ni` is high, nothing is accepted and no state changes.
- R3: ACTIVE to a closed bank `ba_i` opens it and records `addr_i` as its row, which is shown on `row_o`. ACTIVE to a bank that is already open raises `proto_err_o` and changes nothing.
- R4: READ or WRITE to an open bank strobes with `col_o` equal to `addr_i` with bit AP_BIT (10) cleared, `auto_pre_o` equal to `addr_i[10]`, and `row_o` equal to the bank's open row. READ or WRITE to a closed bank raises `proto_err_o` and gives no strobe.
- R5: An accepted READ or WRITE with `auto_pre_o` high closes its bank on the same edge.
- R6: PRECHARGE with `addr_i[10]` low closes only bank `ba_i`. With `addr_i[10]` high it closes every bank. Either form strobes, even when the targeted banks are already closed.
- R7: LOAD MODE with `ba_i`=0 stores `addr_i` in `mode_reg_o`, and with `ba_i`=1 stores it in `ext_mode_reg_o`. Any other `ba_i` raises `proto_err_o` and stores nothing.
- R8: REFRESH with all banks closed strobes. With any bank open it raises `proto_err_o` and has no effect.
- R9: When the block is active, `cke_i` is sampled low and no self-refresh is requested, the state moves to 1 (precharge power-down) if all banks are closed, or to 2 (active power-down) if any bank is open. The command sampled at that edge is ignored.
- R10: REFRESH sampled with `cke_i` low, while active and with all banks closed, strobes code 8 and moves the state to 3 (self refresh). With a bank open, it raises `proto_err_o` and the state goes to 2.
- R11: In states 1, 2 and 3, every command is ignored. This includes the command at the edge where `cke_i` is first sampled high again; that edge returns the state to 0.
- R12: `proto_err_o` pulses when `cke_i` is sampled low in the active state while an access is in progress. An access is in progress when a READ or WRITE is sampled at that same edge, or when one was accepted within the previous BURST_CYC edges.
- R13: BURST STOP strobes code 7 and ends any access in progress, so that a later drop of `cke_i` is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Address / opcode bus |
| cmd_valid_o | output | 1 | Accepted-command strobe |
| cmd_o | output | 4 | Accepted command code |
| bank_o | output | BA_W | Target bank of last command |
| row_o | output | ADDR_W | Row of last ACT/RD/WR |
| col_o | output | ADDR_W | Column of last RD/WR |
| auto_pre_o | output | 1 | Auto-precharge of last RD/WR |
| mode_reg_o | output | ADDR_W | Mode register value |
| ext_mode_reg_o | output | ADDR_W | Extended mode register value |
| bank_open_o | output | NUM_BANKS | Per-bank open flags |
| pwr_state_o | output | 2 | 0 active, 1 precharge PD, 2 active PD, 3 self refresh |
| proto_err_o | output | 1 | Protocol error pulse |

## Verification
The bench builds the block with four banks, a 13-bit address and BURST_CYC reduced to 3. With four banks, the reserved bank codes 2 and 3 of LOAD MODE can be reached. It also makes it possible to open several banks before a close-all precharge. The short burst window lets a directed sequence hit both sides of the access-in-progress boundary within a few cycles. A long random stream is also run, with clock enable held high most of the time. It mixes every opcode against a behavioural model.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_REF  = 4'd5,
    CMD_MRS  = 4'd6,
    CMD_BST  = 4'd7,
    CMD_SREF = 4'd8
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE   = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } ddr_pwr_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  output ddr_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BA_W-1:0]      bank_sel_i,
  input  logic                 open_en_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic                 close_en_i,
  input  logic                 close_all_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic [ROW_W-1:0]     sel_row_o,
  output logic                 any_open_o
);
  logic [ROW_W-1:0] row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel_i == BA_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (close_all_i || (close_en_i && hit)) begin
        open_o[b] <= 1'b0;
      end else if (open_en_i && hit) begin
        open_o[b] <= 1'b1;
        row_q[b]  <= row_i;
      end
    end
  end

  assign sel_row_o  = row_q[bank_sel_i];
  assign any_open_o = |open_o;
endmodule

// File: rtl/ddr_power_fsm.sv
module ddr_power_fsm
  import ddr_cmd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cke_i,
  input  logic     any_open_i,
  input  logic     sref_req_i,
  output ddr_pwr_e state_o
);
  ddr_pwr_e state_d;

  always_comb begin
    state_d = state_o;
    if (state_o == PWR_ACTIVE) begin
      if (!cke_i) begin
        if (sref_req_i)      state_d = PWR_SELF_REF;
        else if (any_open_i) state_d = PWR_ACT_PD;
        else                 state_d = PWR_PRE_PD;
      end
    end else if (cke_i) begin
      state_d = PWR_ACTIVE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= PWR_ACTIVE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int BURST_CYC = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 cke_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 cmd_valid_o,
  output logic [3:0]           cmd_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [ADDR_W-1:0]    row_o,
  output logic [ADDR_W-1:0]    col_o,
  output logic                 auto_pre_o,
  output logic [ADDR_W-1:0]    mode_reg_o,
  output logic [ADDR_W-1:0]    ext_mode_reg_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic [1:0]           pwr_state_o,
  output logic                 proto_err_o
);
  localparam int CNT_W = $clog2(BURST_CYC + 1);
  localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

  ddr_cmd_e         cmd;
  ddr_pwr_e         pwr_q;
  logic [ADDR_W-1:0] sel_row;
  logic             any_open;
  logic [CNT_W-1:0] busy_q;

  logic strobe, err, open_en, close_en, close_all, sref_req;
  logic ld_mode, ld_ext, rw_ok, bst_ok;
  ddr_cmd_e strobe_cmd;

  ddr_cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  ddr_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ADDR_W)) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bank_sel_i (ba_i),
    .open_en_i  (open_en),
    .row_i      (addr_i),
    .close_en_i (close_en),
    .close_all_i(close_all),
    .open_o     (bank_open_o),
    .sel_row_o  (sel_row),
    .any_open_o (any_open)
  );

  ddr_power_fsm u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_i     (cke_i),
    .any_open_i(any_open),
    .sref_req_i(sref_req),
    .state_o   (pwr_q)
  );

  logic active, sel_open, is_rw, acc_busy;
  assign active   = (pwr_q == PWR_ACTIVE);
  assign sel_open = bank_open_o[ba_i];
  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign acc_busy = (busy_q != '0) || is_rw;

  always_comb begin
    strobe = 1'b0; err = 1'b0; strobe_cmd = cmd;
    open_en = 1'b0; close_en = 1'b0; close_all = 1'b0; sref_req = 1'b0;
    ld_mode = 1'b0; ld_ext = 1'b0; rw_ok = 1'b0; bst_ok = 1'b0;
    if (active && cke_i) begin
      unique case (cmd)
        CMD_ACT: if (sel_open) err = 1'b1;
                 else begin open_en = 1'b1; strobe = 1'b1; end
        CMD_RD, CMD_WR:
                 if (!sel_open) err = 1'b1;
                 else begin
                   strobe = 1'b1; rw_ok = 1'b1;
                   close_en = addr_i[AP_BIT];
                 end
        CMD_PRE: begin
                   strobe = 1'b1;
                   if (addr_i[AP_BIT]) close_all = 1'b1;
                   else                close_en  = 1'b1;
                 end
        CMD_REF: if (any_open) err = 1'b1; else strobe = 1'b1;
        CMD_MRS: if (ba_i == BA_W'(0))      begin ld_mode = 1'b1; strobe = 1'b1; end
                 else if (ba_i == BA_W'(1)) begin ld_ext  = 1'b1; strobe = 1'b1; end
                 else err = 1'b1;
        CMD_BST: begin strobe = 1'b1; bst_ok = 1'b1; end
        default: ;
      endcase
    end else if (active && !cke_i) begin
      if (acc_busy) err = 1'b1;
      if (cmd == CMD_REF) begin
        if (any_open) err = 1'b1;
        else begin sref_req = 1'b1; strobe = 1'b1; strobe_cmd = CMD_SREF; end
      end
    end
  end

  // access window counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= '0;
    else if (rw_ok)       busy_q <= CNT_W'(BURST_CYC);
    else if (bst_ok)      busy_q <= '0;
    else if (busy_q != '0) busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o    <= 1'b0;
      cmd_o          <= CMD_NOP;
      bank_o         <= '0;
      row_o          <= '0;
      col_o          <= '0;
      auto_pre_o     <= 1'b0;
      mode_reg_o     <= '0;
      ext_mode_reg_o <= '0;
      proto_err_o    <= 1'b0;
    end else begin
      cmd_valid_o <= strobe;
      proto_err_o <= err;
      if (strobe) begin
        cmd_o  <= strobe_cmd;
        bank_o <= ba_i;
      end
      if (open_en) row_o <= addr_i;
      if (rw_ok) begin
        row_o      <= sel_row;
        col_o      <= addr_i & ~AP_MASK;
        auto_pre_o <= addr_i[AP_BIT];
      end
      if (ld_mode) mode_reg_o     <= addr_i;
      if (ld_ext)  ext_mode_reg_o <= addr_i;
    end
  end

  assign pwr_state_o = pwr_q;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_ni,
  input logic                 ras_ni,
  input logic                 cas_ni,
  input logic                 we_ni,
  input logic                 cke_i,
  input logic [BA_W-1:0]      ba_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 cmd_valid_o,
  input logic [3:0]           cmd_o,
  input logic [BA_W-1:0]      bank_o,
  input logic [ADDR_W-1:0]    row_o,
  input logic [ADDR_W-1:0]    col_o,
  input logic                 auto_pre_o,
  input logic [ADDR_W-1:0]    mode_reg_o,
  input logic [ADDR_W-1:0]    ext_mode_reg_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic [1:0]           pwr_state_o,
  input logic                 proto_err_o
);
  logic live;
  assign live = (pwr_state_o == 2'd0) && cke_i && !cs_ni;

  p_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !cmd_valid_o);
  p_mask_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && cke_i && pwr_state_o == 2'd0) |=> !proto_err_o);
  p_act_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 4'd1) |-> bank_open_o[bank_o]);
  p_act_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && {ras_ni, cas_ni, we_ni} == 3'b011 && !bank_open_o[ba_i])
    |=> row_o == $past(addr_i));
  p_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_o == 4'd2 || cmd_o == 4'd3)) |-> !col_o[AP_BIT]);
  p_ap_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && (cmd_o == 4'd2 || cmd_o == 4'd3) && auto_pre_o)
    |-> !bank_open_o[bank_o]);
  p_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && {ras_ni, cas_ni, we_ni} == 3'b000 && ba_i == BA_W'(0))
    |=> mode_reg_o == $past(addr_i));
  p_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && {ras_ni, cas_ni, we_ni} == 3'b000 && ba_i == BA_W'(1))
    |=> ext_mode_reg_o == $past(addr_i));
  p_pd_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd0 && !cke_i && (|bank_open_o)) |=> pwr_state_o == 2'd2);
  p_pd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd0 && !cke_i && !(|bank_open_o)) |=> pwr_state_o != 2'd2);
  p_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o != 2'd0) |=> (!cmd_valid_o && $stable(bank_open_o)));
  p_wake_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o != 2'd0 && cke_i) |=> pwr_state_o == 2'd0);
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
) u_chk (.*);

// File: tb/ddr_cmd_tracker_test.sv
module ddr_cmd_tracker_test;
  localparam int NB  = 4;
  localparam int AW  = 13;
  localparam int BC  = 3;
  localparam int BAW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [BAW-1:0] ba = '0;
  logic [AW-1:0]  addr = '0;

  logic          cmd_valid, auto_pre, perr;
  logic [3:0]    cmd;
  logic [BAW-1:0] bank;
  logic [AW-1:0] row, col, mode, emode;
  logic [NB-1:0] bopen;
  logic [1:0]    pwr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ddr_cmd_tracker #(.NUM_BANKS(NB), .ADDR_W(AW), .AP_BIT(10), .BURST_CYC(BC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .addr_i(addr),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .bank_o(bank), .row_o(row), .col_o(col),
    .auto_pre_o(auto_pre), .mode_reg_o(mode), .ext_mode_reg_o(emode),
    .bank_open_o(bopen), .pwr_state_o(pwr), .proto_err_o(perr)
  );

  // behavioural reference
  bit        m_open [NB];
  int        m_rows [NB];
  int        m_mode, m_emode, m_pwr, m_busy, m_cmd, m_bank, m_row, m_col;
  bit        m_valid, m_ap, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_open[i]) begin m_open[i] = 0; m_rows[i] = 0; end
      m_mode = 0; m_emode = 0; m_pwr = 0; m_busy = 0;
      m_cmd = 0; m_bank = 0; m_row = 0; m_col = 0;
      m_valid = 0; m_ap = 0; m_err = 0;
    end else begin
      int  op, nb, anyo;
      bit  rw_ok, bst_ok;
      op = cs_n ? 7 : {ras_n, cas_n, we_n};
      nb = m_busy;
      rw_ok = 0; bst_ok = 0;
      m_valid = 0; m_err = 0;
      anyo = 0;
      foreach (m_open[i]) anyo += m_open[i];
      if (m_pwr == 0 && cke) begin
        case (op)
          3: if (m_open[ba]) m_err = 1;
             else begin m_open[ba] = 1; m_rows[ba] = addr; m_row = addr;
                        m_valid = 1; m_cmd = 1; m_bank = ba; end
          5, 4: if (!m_open[ba]) m_err = 1;
             else begin
               m_valid = 1; m_cmd = (op == 5) ? 2 : 3; m_bank = ba;
               m_row = m_rows[ba]; m_col = addr & ~(1 << 10); m_ap = addr[10];
               if (addr[10]) m_open[ba] = 0;
               rw_ok = 1;
             end
          2: begin
               m_valid = 1; m_cmd = 4; m_bank = ba;
               if (addr[10]) foreach (m_open[i]) m_open[i] = 0;
               else m_open[ba] = 0;
             end
          1: if (anyo != 0) m_err = 1;
             else begin m_valid = 1; m_cmd = 5; m_bank = ba; end
          0: if (ba == 0)      begin m_mode = addr;  m_valid = 1; m_cmd = 6; m_bank = ba; end
             else if (ba == 1) begin m_emode = addr; m_valid = 1; m_cmd = 6; m_bank = ba; end
             else m_err = 1;
          6: begin m_valid = 1; m_cmd = 7; m_bank = ba; bst_ok = 1; end
          default: ;
        endcase
      end else if (m_pwr == 0 && !cke) begin
        if (m_busy != 0 || op == 5 || op == 4) m_err = 1;
        if (op == 1 && anyo == 0) begin
          m_valid = 1; m_cmd = 8; m_bank = ba; m_pwr = 3;
        end else begin
          if (op == 1) m_err = 1;
          m_pwr = (anyo != 0) ? 2 : 1;
        end
      end else if (m_pwr != 0 && cke) begin
        m_pwr = 0;
      end
      if (rw_ok) m_busy = BC;
      else if (bst_ok) m_busy = 0;
      else if (nb != 0) m_busy = nb - 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h @%0t", what, got, exp, $time);
    end
  endtask

  // full comparison every cycle
  always @(negedge clk) if (rst_n) begin
    int mo;
    mo = 0;
    foreach (m_open[i]) mo |= (int'(m_open[i]) << i);
    chk(cmd_valid == m_valid, "R2 cmd_valid", cmd_valid, m_valid);
    chk(int'(cmd) == m_cmd, "R2 cmd", cmd, m_cmd);
    chk(int'(bank) == m_bank, "R2 bank", bank, m_bank);
    chk(int'(bopen) == mo, "R3 bank_open", bopen, mo);
    chk(int'(row) == m_row, "R3 row", row, m_row);
    chk(int'(col) == m_col, "R4 col", col, m_col);
    chk(auto_pre == m_ap, "R4 auto_pre", auto_pre, m_ap);
    chk(int'(mode) == m_mode, "R7 mode", mode, m_mode);
    chk(int'(emode) == m_emode, "R7 ext_mode", emode, m_emode);
    chk(int'(pwr) == m_pwr, "R9 pwr_state", pwr, m_pwr);
    chk(perr == m_err, "R12 proto_err", perr, m_err);
  end

  task automatic cyc(input bit c, input logic [2:0] op, input bit k,
                     input int b, input int a);
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = op; cke = k;
    ba = BAW'(b); addr = AW'(a);
    @(posedge clk); #1;
  endtask

  task automatic nop(input bit k); cyc(1'b0, 3'b111, k, 0, 0); endtask

  initial begin : watchdog
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(bopen == '0 && mode == '0 && emode == '0 && pwr == 2'd0 && !cmd_valid && !perr,
        "R1 reset state", {bopen, pwr}, 0);
    rst_n = 1'b1;
    cyc(1'b1, 3'b011, 1, 0, 'h123);
    chk(bopen == '0 && !cmd_valid, "R2 deselected act", bopen, 0);
    cyc(1'b0, 3'b011, 1, 0, 'h123);
    cyc(1'b0, 3'b011, 1, 0, 'h321);
    chk(perr && row == 'h123, "R3 act to open bank", row, 'h123);
    cyc(1'b0, 3'b011, 1, 2, 'h55);
    cyc(1'b0, 3'b101, 1, 0, 'h404);
    chk(!bopen[0] && auto_pre && col == 'h004, "R5 auto precharge", {bopen, col}, 'h004);
    cyc(1'b0, 3'b100, 1, 1, 'h10);
    chk(perr && !cmd_valid, "R4 write closed bank", perr, 1);
    cyc(1'b0, 3'b100, 1, 2, 'h12);
    nop(1); nop(1); nop(1);
    cyc(1'b0, 3'b000, 1, 0, 'h33);
    cyc(1'b0, 3'b000, 1, 1, 'h1);
    cyc(1'b0, 3'b000, 1, 2, 'h7);
    chk(perr && mode == 'h33 && emode == 'h1, "R7 reserved select", mode, 'h33);
    cyc(1'b0, 3'b001, 1, 0, 0);
    chk(perr && !cmd_valid, "R8 refresh with open bank", perr, 1);
    cyc(1'b0, 3'b010, 1, 2, 0);
    cyc(1'b0, 3'b011, 1, 1, 'h9);
    cyc(1'b0, 3'b011, 1, 3, 'ha);
    cyc(1'b0, 3'b010, 1, 0, 'h400);
    chk(bopen == '0, "R6 precharge all", bopen, 0);
    cyc(1'b0, 3'b001, 1, 0, 0);
    chk(cmd_valid && cmd == 4'd5, "R8 refresh idle", cmd, 5);
    nop(0);
    chk(pwr == 2'd1, "R9 precharge power-down", pwr, 1);
    cyc(1'b0, 3'b011, 0, 1, 'h5);
    cyc(1'b0, 3'b011, 1, 1, 'h5);
    chk(pwr == 2'd0 && bopen == '0 && !cmd_valid, "R11 commands ignored", bopen, 0);
    cyc(1'b0, 3'b011, 1, 1, 'h5);
    nop(0);
    chk(pwr == 2'd2, "R9 active power-down", pwr, 2);
    nop(1);
    cyc(1'b0, 3'b010, 1, 0, 'h400);
    cyc(1'b0, 3'b001, 0, 0, 0);
    chk(pwr == 2'd3 && cmd == 4'd8, "R10 self refresh entry", pwr, 3);
    nop(0); nop(0); nop(1);
    cyc(1'b0, 3'b011, 1, 0, 'h77);
    cyc(1'b0, 3'b101, 1, 0, 'h8);
    nop(0);
    chk(perr, "R12 cke low during burst", perr, 1);
    nop(1);
    cyc(1'b0, 3'b101, 1, 0, 'h8);
    cyc(1'b0, 3'b110, 1, 0, 0);
    chk(cmd_valid && cmd == 4'd7, "R13 burst stop strobe", cmd, 7);
    nop(0);
    chk(!perr, "R13 cke low after stop", perr, 0);
    nop(1);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      cyc(r == 15, 3'($urandom_range(0, 7)), $urandom_range(0, 9) != 0,
          $urandom_range(0, NB - 1), $urandom_range(0, (1 << AW) - 1));
    end
    nop(1); nop(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule